// File: doc/BRIEF.md
# Queue Interrupt Source Selector

This block raises interrupt requests for a bank of 64 hardware queues. The queues form two halves of 32, and each half drives its own interrupt line. Every queue reports four status flags: empty, nearly empty, nearly full and full. In the lower half, software picks per queue which flag is watched and whether that flag is inverted first. Every upper-half queue watches the same fixed condition, which is its nearly-empty flag being low.

A queue latches a pending bit when its watched condition goes from low to high while the queue is enabled. Software clears pending bits by writing ones to them. Turning a queue's enable off also drops its pending bit. All configuration and status goes through one register port, with a write in a single cycle and read data that follows the address combinationally. The same port also gives a readback of the live queue flags.

Top module: `qis_irq_select`

## Requirements
- R1: After reset, every source-select word, both enable words and both status words read 0, and both interrupt lines are low.
- R2: Source-select words sit at addresses 0 to 3. Queue q (0 to 31) keeps its 3-bit code in word q/8, bits 4*(q%8)+2 down to 4*(q%8). Bit 3 of each nibble ignores writes and reads 0.
- R3: In a lower-half code, bits 1:0 choose the flag: 0 empty, 1 nearly empty, 2 nearly full, 3 full. Bit 2 set inverts that flag. Codes 4 to 7 are therefore not-empty, not-nearly-empty, not-nearly-full and not-full.
- R4: A queue's status bit sets when its condition goes from 0 to 1 while the queue is enabled. A condition that stays high sets nothing more. Enabling a queue whose condition is already high sets nothing.
- R5: A condition edge on a disabled queue leaves its status bit at 0.
- R6: Upper-half queue 32+i (bit i of the upper words) always uses not-nearly-empty and ignores its empty, nearly-full and full flags.
- R7: Writing address 6 (lower) or 7 (upper) clears each status bit written as 1. Bits written as 0 keep their value. Enable words are at 4 (lower) and 5 (upper), one bit per queue.
- R8: When a clear-by-write and a set event hit the same status bit in the same cycle, the bit ends up set.
- R9: A write that changes an enable bit from 1 to 0 clears that queue's status bit on the same clock edge. Re-enabling does not restore the bit.
- R10: irq_lo is the OR over the lower half of status AND enable, and irq_hi is the same over the upper half. The two halves do not affect each other.
- R11: Addresses 8 to 11 return the lower-half flags as nibbles in the same packing as R2: bit 0 empty, bit 1 nearly empty, bit 2 nearly full, bit 3 full. Address 12 returns the upper nearly-empty vector and address 13 the upper full vector. Addresses 14 and 15 read 0.
- R12: A flag change seen at one clock edge shows up in status and on the interrupt line right after that same edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| q_empty | input | 64 | Per-queue empty flag |
| q_nempty | input | 64 | Per-queue nearly-empty flag |
| q_nfull | input | 64 | Per-queue nearly-full flag |
| q_full | input | 64 | Per-queue full flag |
| irq_lo | output | 1 | Interrupt request, queues 0 to 31 |
| irq_hi | output | 1 | Interrupt request, queues 32 to 63 |

## Verification
All eight codes are applied to the whole lower half, one code at a time. Under each code, random pairs of old and new flag vectors are driven, so the expected status shows at once whether the right flag is selected, whether inversion is applied and whether only rising edges count. A mixed pass then gives neighbouring queues different codes and sparse enables, which exposes nibble-position mistakes and a missing enable gate. Directed sequences cover the timing-sensitive cases: clear and set in the same cycle, a disable write that clears status, enabling while a condition is held high, and upper queues staying deaf to every flag except nearly-empty.

// File: rtl/qis_pkg.sv
`timescale 1ns/1ps
package qis_pkg;
  localparam int CODE_W = 3;
  localparam int NIB_W  = 4;

  typedef enum logic [CODE_W-1:0] {
    SRC_EMPTY      = 3'd0,
    SRC_NEMPTY     = 3'd1,
    SRC_NFULL      = 3'd2,
    SRC_FULL       = 3'd3,
    SRC_NOT_EMPTY  = 3'd4,
    SRC_NOT_NEMPTY = 3'd5,
    SRC_NOT_NFULL  = 3'd6,
    SRC_NOT_FULL   = 3'd7
  } src_code_e;

  // bit 0 empty .. bit 3 full
  typedef struct packed {
    logic full;
    logic nfull;
    logic nempty;
    logic empty;
  } qflags_t;

  function automatic logic pick_cond(input qflags_t f, input logic [CODE_W-1:0] code);
    logic [3:0] v;
    v = f;
    return v[code[1:0]] ^ code[2];
  endfunction
endpackage

// File: rtl/qis_cond_edge.sv
`timescale 1ns/1ps
module qis_cond_edge
  import qis_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        f_empty,
  input  logic [N-1:0]        f_nempty,
  input  logic [N-1:0]        f_nfull,
  input  logic [N-1:0]        f_full,
  input  logic [N*CODE_W-1:0] codes,
  output logic [N-1:0]        rise
);
  logic [N-1:0] cond;
  logic [N-1:0] cond_q;
  logic [N-1:0] cond_n;

  for (genvar q = 0; q < N; q++) begin : g_q
    qflags_t fl;
    assign fl      = '{full: f_full[q], nfull: f_nfull[q], nempty: f_nempty[q], empty: f_empty[q]};
    assign cond[q] = pick_cond(fl, codes[q*CODE_W +: CODE_W]);
  end

  always_comb begin
    cond_n = cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond_n;
  end

  assign rise = cond & ~cond_q;
endmodule

// File: rtl/qis_half_ctl.sv
`timescale 1ns/1ps
module qis_half_ctl #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic [N-1:0] en_data,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  input  logic [N-1:0] rise,
  output logic [N-1:0] en_o,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, en_n;
  logic [N-1:0] sts_q, sts_n;
  logic [N-1:0] set_v, clr_v, dis_v;

  always_comb begin
    en_n  = en_we  ? en_data  : en_q;
    clr_v = clr_we ? clr_data : '0;
    set_v = rise & en_n;
    dis_v = en_q & ~en_n;
    sts_n = (sts_q & ~clr_v & ~dis_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (en_we) en_q <= en_n;
      sts_q <= sts_n;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_q);

  assert_status_within_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~en_q) == '0));
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & $past(clr_v & ~set_v)) == '0));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & $past(set_v)) == $past(set_v)));
  assert_only_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(set_v)) == '0));
endmodule

// File: rtl/qis_irq_select.sv
`timescale 1ns/1ps
module qis_irq_select
  import qis_pkg::*;
#(
  parameter  int HALF_Q    = 32,
  localparam int DATA_W    = HALF_Q,
  localparam int QPW       = DATA_W / NIB_W,
  localparam int SRC_WORDS = HALF_Q / QPW,
  localparam int NREG      = 2 * SRC_WORDS + 6,
  localparam int AW        = $clog2(NREG),
  localparam int NQ        = 2 * HALF_Q
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NQ-1:0]     q_empty,
  input  logic [NQ-1:0]     q_nempty,
  input  logic [NQ-1:0]     q_nfull,
  input  logic [NQ-1:0]     q_full,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int A_EN_LO = SRC_WORDS;
  localparam int A_EN_HI = SRC_WORDS + 1;
  localparam int A_ST_LO = SRC_WORDS + 2;
  localparam int A_ST_HI = SRC_WORDS + 3;
  localparam int A_FLG0  = SRC_WORDS + 4;
  localparam int A_NE_HI = A_FLG0 + SRC_WORDS;
  localparam int A_FU_HI = A_NE_HI + 1;
  localparam logic [CODE_W-1:0] HI_CODE = CODE_W'(SRC_NOT_NEMPTY);
  localparam logic [DATA_W-1:0] RSV_MASK = {QPW{4'b1000}};

  logic [CODE_W-1:0] src_q [HALF_Q];
  logic [CODE_W-1:0] src_n [HALF_Q];
  logic [HALF_Q*CODE_W-1:0] codes_lo, codes_hi;
  logic [HALF_Q-1:0] rise_lo, rise_hi;
  logic [HALF_Q-1:0] en_lo, en_hi, sts_lo, sts_hi;
  logic we_en_lo, we_en_hi, we_st_lo, we_st_hi;

  // source select registers
  always_comb begin
    for (int q = 0; q < HALF_Q; q++) src_n[q] = src_q[q];
    if (reg_we) begin
      for (int w = 0; w < SRC_WORDS; w++) begin
        if (reg_addr == AW'(w)) begin
          for (int k = 0; k < QPW; k++) src_n[w*QPW+k] = reg_wdata[k*NIB_W +: CODE_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < HALF_Q; q++) src_q[q] <= '0;
    end else begin
      for (int q = 0; q < HALF_Q; q++) src_q[q] <= src_n[q];
    end
  end

  for (genvar q = 0; q < HALF_Q; q++) begin : g_codes
    assign codes_lo[q*CODE_W +: CODE_W] = src_q[q];
    assign codes_hi[q*CODE_W +: CODE_W] = HI_CODE;
  end

  assign we_en_lo = reg_we && (reg_addr == AW'(A_EN_LO));
  assign we_en_hi = reg_we && (reg_addr == AW'(A_EN_HI));
  assign we_st_lo = reg_we && (reg_addr == AW'(A_ST_LO));
  assign we_st_hi = reg_we && (reg_addr == AW'(A_ST_HI));

  qis_cond_edge #(.N(HALF_Q)) u_cond_lo (
    .clk(clk), .rst_n(rst_n),
    .f_empty(q_empty[HALF_Q-1:0]), .f_nempty(q_nempty[HALF_Q-1:0]),
    .f_nfull(q_nfull[HALF_Q-1:0]), .f_full(q_full[HALF_Q-1:0]),
    .codes(codes_lo), .rise(rise_lo)
  );

  qis_cond_edge #(.N(HALF_Q)) u_cond_hi (
    .clk(clk), .rst_n(rst_n),
    .f_empty(q_empty[NQ-1:HALF_Q]), .f_nempty(q_nempty[NQ-1:HALF_Q]),
    .f_nfull(q_nfull[NQ-1:HALF_Q]), .f_full(q_full[NQ-1:HALF_Q]),
    .codes(codes_hi), .rise(rise_hi)
  );

  qis_half_ctl #(.N(HALF_Q)) u_ctl_lo (
    .clk(clk), .rst_n(rst_n),
    .en_we(we_en_lo), .en_data(reg_wdata),
    .clr_we(we_st_lo), .clr_data(reg_wdata),
    .rise(rise_lo), .en_o(en_lo), .sts_o(sts_lo), .irq_o(irq_lo)
  );

  qis_half_ctl #(.N(HALF_Q)) u_ctl_hi (
    .clk(clk), .rst_n(rst_n),
    .en_we(we_en_hi), .en_data(reg_wdata),
    .clr_we(we_st_hi), .clr_data(reg_wdata),
    .rise(rise_hi), .en_o(en_hi), .sts_o(sts_hi), .irq_o(irq_hi)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < SRC_WORDS; w++) begin
      if (reg_addr == AW'(w)) begin
        for (int k = 0; k < QPW; k++) reg_rdata[k*NIB_W +: CODE_W] = src_q[w*QPW+k];
      end
      if (reg_addr == AW'(A_FLG0 + w)) begin
        for (int k = 0; k < QPW; k++) begin
          reg_rdata[k*NIB_W +: NIB_W] = {q_full[w*QPW+k], q_nfull[w*QPW+k],
                                         q_nempty[w*QPW+k], q_empty[w*QPW+k]};
        end
      end
    end
    if (reg_addr == AW'(A_EN_LO)) reg_rdata = en_lo;
    if (reg_addr == AW'(A_EN_HI)) reg_rdata = en_hi;
    if (reg_addr == AW'(A_ST_LO)) reg_rdata = sts_lo;
    if (reg_addr == AW'(A_ST_HI)) reg_rdata = sts_hi;
    if (reg_addr == AW'(A_NE_HI)) reg_rdata = q_nempty[NQ-1:HALF_Q];
    if (reg_addr == AW'(A_FU_HI)) reg_rdata = q_full[NQ-1:HALF_Q];
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < AW'(SRC_WORDS)) |-> ((reg_rdata & RSV_MASK) == '0));
  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_hi & ~$past(sts_hi) & $past(q_nempty[NQ-1:HALF_Q])) == '0));
endmodule

// File: tb/sim_qis_irq_select.sv
`timescale 1ns/1ps
module sim_qis_irq_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] fe = '1, fne = '1, fnf = '0, ff = '0;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int code_of [32];
  logic [31:0] en_lo_m, en_hi_m;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  qis_irq_select u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .q_empty(fe), .q_nempty(fne), .q_nfull(fnf), .q_full(ff),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic cond_of(input int c, input logic e, n, nf, f);
    logic v;
    case (c % 4)
      0: v = e;
      1: v = n;
      2: v = nf;
      default: v = f;
    endcase
    return (c >= 4) ? ~v : v;
  endfunction

  task automatic prog_codes();
    for (int w = 0; w < 4; w++) begin
      logic [31:0] d;
      d = '0;
      for (int k = 0; k < 8; k++) d[k*4 +: 4] = {1'b0, 3'(code_of[w*8+k])};
      wr(4'(w), d);
    end
  endtask

  task automatic trial(input string tag);
    logic [63:0] e0, n0, nf0, f0, e1, n1, nf1, f1;
    logic [31:0] exp_lo, exp_hi, got;
    e0 = rnd(); n0 = rnd(); nf0 = rnd(); f0 = rnd();
    e1 = rnd(); n1 = rnd(); nf1 = rnd(); f1 = rnd();
    @(negedge clk);
    fe = e0; fne = n0; fnf = nf0; ff = f0;
    @(negedge clk);
    @(negedge clk);
    wr(4'd6, '1);
    wr(4'd7, '1);
    for (int q = 0; q < 32; q++) begin
      exp_lo[q] = en_lo_m[q] & cond_of(code_of[q], e1[q], n1[q], nf1[q], f1[q])
                  & ~cond_of(code_of[q], e0[q], n0[q], nf0[q], f0[q]);
      exp_hi[q] = en_hi_m[q] & ~n1[32+q] & n0[32+q];
    end
    @(negedge clk);
    fe = e1; fne = n1; fnf = nf1; ff = f1;
    rd(4'd6, got);
    chk({"R12 before edge ", tag}, got, 32'h0);
    @(negedge clk);
    rd(4'd6, got);
    chk({"R3 R4 status lo ", tag}, got, exp_lo);
    chk({"R10 irq_lo ", tag}, {31'b0, irq_lo}, {31'b0, |exp_lo});
    rd(4'd7, got);
    chk({"R6 status hi ", tag}, got, exp_hi);
    chk({"R10 irq_hi ", tag}, {31'b0, irq_hi}, {31'b0, |exp_hi});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), got);
      chk($sformatf("R1 reset addr %0d", a), got, 32'h0);
    end
    chk("R1 irq_lo reset", {31'b0, irq_lo}, 32'h0);
    chk("R1 irq_hi reset", {31'b0, irq_hi}, 32'h0);
    rd(4'd8, got);  chk("R11 lo flags after reset", got, 32'h3333_3333);
    rd(4'd12, got); chk("R11 hi nempty", got, 32'hFFFF_FFFF);
    rd(4'd13, got); chk("R11 hi full", got, 32'h0);

    // R2 reserved bits and packing
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, got); chk("R2 reserved bits", got, 32'h7777_7777);
    wr(4'd2, 32'h89AB_CDEF);
    rd(4'd2, got); chk("R2 nibble packing", got, 32'h0123_4567);

    // R3 sweep over every code on the whole lower half
    en_lo_m = '1; en_hi_m = '1;
    wr(4'd4, en_lo_m);
    wr(4'd5, en_hi_m);
    for (int c = 0; c < 8; c++) begin
      for (int q = 0; q < 32; q++) code_of[q] = c;
      prog_codes();
      for (int t = 0; t < 6; t++) trial($sformatf("code %0d trial %0d", c, t));
    end

    // mixed codes, sparse enables (R2 R5)
    for (int q = 0; q < 32; q++) code_of[q] = (q * 5 + 3) % 8;
    prog_codes();
    en_lo_m = 32'hA5C3_0F69; en_hi_m = 32'h3C3C_F00F;
    wr(4'd4, en_lo_m);
    wr(4'd5, en_hi_m);
    for (int t = 0; t < 12; t++) trial($sformatf("R2 R5 mixed trial %0d", t));

    // R4 enabling while the condition is already high
    for (int q = 0; q < 32; q++) code_of[q] = 0;
    prog_codes();
    wr(4'd4, 32'h0);
    @(negedge clk);
    fe = '1; fne = '1; fnf = '0; ff = '0;
    repeat (2) @(negedge clk);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd6, got); chk("R4 enable while held", got, 32'h0);
    repeat (3) @(negedge clk);
    rd(4'd6, got); chk("R4 held high no set", got, 32'h0);
    chk("R4 irq_lo stays low", {31'b0, irq_lo}, 32'h0);

    // R5 edge while disabled
    wr(4'd4, 32'h0);
    @(negedge clk); fe[31:0] = '0;
    repeat (2) @(negedge clk);
    fe[31:0] = '1;
    @(negedge clk);
    rd(4'd6, got); chk("R5 disabled edge", got, 32'h0);
    chk("R5 irq_lo", {31'b0, irq_lo}, 32'h0);

    // R8 set wins over clear
    wr(4'd4, 32'hFFFF_FFFF);
    @(negedge clk); fe[31:0] = '0;
    repeat (2) @(negedge clk);
    fe[31:0] = 32'h0000_00FF;
    @(negedge clk);
    rd(4'd6, got); chk("R4 rise sets", got, 32'h0000_00FF);
    @(negedge clk);
    fe[31:0] = 32'h0000_FFFF;
    reg_we = 1'b1; reg_addr = 4'd6; reg_wdata = '1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(4'd6, got); chk("R8 set wins over clear", got, 32'h0000_FF00);

    // R7 partial clear and zero write
    wr(4'd6, 32'h0000_0F00);
    rd(4'd6, got); chk("R7 partial clear", got, 32'h0000_F000);
    wr(4'd6, 32'h0);
    rd(4'd6, got); chk("R7 zero write keeps", got, 32'h0000_F000);

    // R9 disable clears
    wr(4'd4, 32'hFFFF_7FFF);
    rd(4'd6, got); chk("R9 disable clears bit", got, 32'h0000_7000);
    chk("R10 irq_lo still high", {31'b0, irq_lo}, 32'h1);
    rd(4'd4, got); chk("R7 enable readback", got, 32'hFFFF_7FFF);
    wr(4'd4, 32'hFFFF_0FFF);
    rd(4'd6, got); chk("R9 all cleared", got, 32'h0);
    chk("R10 irq_lo low", {31'b0, irq_lo}, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd6, got); chk("R9 re-enable no restore", got, 32'h0);

    // R6 upper half ignores other flags; R10 halves independent
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    @(negedge clk);
    fe[63:32] = '0; fnf[63:32] = '1; ff[63:32] = '1;
    repeat (2) @(negedge clk);
    fe[63:32] = '1; fnf[63:32] = '0; ff[63:32] = '0;
    @(negedge clk);
    fnf[63:32] = '1; ff[63:32] = '1;
    @(negedge clk);
    rd(4'd7, got); chk("R6 other flags ignored", got, 32'h0);
    fne[63:32] = 32'hFFFF_FFF0;
    @(negedge clk);
    rd(4'd7, got); chk("R6 not-nearly-empty sets", got, 32'h0000_000F);
    chk("R10 irq_hi high", {31'b0, irq_hi}, 32'h1);
    chk("R10 irq_lo unaffected", {31'b0, irq_lo}, 32'h0);

    // R11 flag readback
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      fe = rnd(); fne = rnd(); fnf = rnd(); ff = rnd();
      for (int w = 0; w < 4; w++) begin
        logic [31:0] ex;
        for (int k = 0; k < 8; k++)
          ex[k*4 +: 4] = {ff[w*8+k], fnf[w*8+k], fne[w*8+k], fe[w*8+k]};
        rd(4'(8 + w), got);
        chk($sformatf("R11 lo flag word %0d", w), got, ex);
      end
      rd(4'd12, got); chk("R11 hi nempty", got, fne[63:32]);
      rd(4'd13, got); chk("R11 hi full", got, ff[63:32]);
    end
    rd(4'd14, got); chk("R11 unmapped 14", got, 32'h0);
    rd(4'd15, got); chk("R11 unmapped 15", got, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule